// File: doc/BRIEF.md
# Board Control Status and Parity Capture

This block is the host-facing register set of a network interface board. A single 16-bit status/control word lets the host hold the network controller in reset, release the link from loopback onto the medium, pulse channel attention, enable the secondary memory bus, flag the use of 256 Kb RAM parts, and enable two interrupt sources. The same word reads back two live flags and four strap bits. The straps give the high physical address bits of the board RAM base; software shifts them left by 16 to form that base.

Memory parity errors arrive from outside as a one-cycle strobe with the failing address, the byte lane and the error source. The block captures the first error, raises a flag and holds the details until the host acknowledges. It merges the controller interrupt and the parity error into one host interrupt line, each gated by its own enable bit.

Top module: `bcs_regs`

## Requirements
- R1: After synchronous reset every writable bit, every captured field, every output and the read data are 0.
- R2: A write to offset 0 stores bits 15, 14, 13, 12, 11, 5 and 4. Bit 15 drives `ctlr_reset_o`, bit 14 drives `on_medium_o`, bit 13 drives `chan_attn_o`, bit 5 drives `sec_bus_en_o` and bit 4 drives `wide_ram_o`. All take effect in the cycle after the write. Bits 10, 7 and 6 read as 0.
- R3: At offset 0, bit 9 reads the parity error flag, bit 8 reads the controller interrupt input registered once, and bits [3:0] read `ram_base_strap_i`. Writes to these bits have no effect.
- R4: A parity strobe with no error pending sets the flag. It also captures the source into offset 1 bit 7, the byte lane into offset 1 bit 6, `par_addr_i[19:16]` into offset 1 bits [3:0], and `par_addr_i[15:0]` into offset 2.
- R5: While an error is pending, further strobes change neither the flag nor the captured fields.
- R6: Writing 1 to offset 1 bit 8 clears the flag and all captured fields. That bit always reads 0. The acknowledge wins over a strobe in the same cycle, and that strobe is discarded.
- R7: `host_irq_o` equals (bit 8 AND bit 12) OR (bit 9 AND bit 11) of the status word, registered one cycle after those bits.
- R8: A read returns data on `host_rdata_o` one cycle later. Offset 3 reads 0. `host_rdata_o` holds its value in cycles with no read.
- R9: Writes to offset 1 other than the acknowledge bit, and all writes to offsets 2 and 3, leave the registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Register word offset |
| host_wdata | input | 16 | Host write data |
| host_rdata_o | output | 16 | Registered read data |
| ram_base_strap_i | input | 4 | RAM base address strap bits |
| ctlr_irq_i | input | 1 | Interrupt request from the controller |
| par_err_i | input | 1 | One-cycle parity error strobe |
| par_src_i | input | 1 | Source of the parity error |
| par_lane_i | input | 1 | Byte lane that failed |
| par_addr_i | input | 20 | Failing memory address |
| ctlr_reset_o | output | 1 | Controller reset |
| on_medium_o | output | 1 | Link out of loopback |
| chan_attn_o | output | 1 | Channel attention |
| sec_bus_en_o | output | 1 | Secondary bus enable |
| wide_ram_o | output | 1 | 256 Kb RAM parts in use |
| host_irq_o | output | 1 | Merged host interrupt |

## Verification
The assertions assume that the host asserts at most one of `host_wr` and `host_rd` in a cycle. They also assume that `par_err_i` is a single-cycle strobe whose address, lane and source are valid in that same cycle. The stimulus drives every input on the falling clock edge. Each host access lasts exactly one cycle, each parity strobe is dropped after one cycle, and the controller interrupt is held for several cycles so that its registered flag settles before it is read.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int REG_W    = 16;
  localparam int PA_HI_W  = 4;
  localparam int PA_LO_W  = 16;
  localparam int PA_W     = PA_HI_W + PA_LO_W;
  localparam int STRAP_W  = 4;

  localparam int OFS_STATUS = 0;
  localparam int OFS_PCTL   = 1;
  localparam int OFS_PLO    = 2;

  localparam int B_RESET  = 15;
  localparam int B_MEDIUM = 14;
  localparam int B_ATTN   = 13;
  localparam int B_IEN    = 12;
  localparam int B_PIEN   = 11;
  localparam int B_PERR   = 9;
  localparam int B_IRQ    = 8;
  localparam int B_SECBUS = 5;
  localparam int B_WIDE   = 4;

  localparam int B_ACK    = 8;
  localparam int B_SRC    = 7;
  localparam int B_LANE   = 6;

  localparam logic [REG_W-1:0] WR_MASK = 16'hF830;

  typedef struct packed {
    logic               src;
    logic               lane;
    logic [PA_HI_W-1:0] hi;
    logic [PA_LO_W-1:0] lo;
  } perr_cap_t;
endpackage

// File: rtl/bcs_ctrl_word.sv
module bcs_ctrl_word
  import bcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ctl_q
);
  always_ff @(posedge clk) begin
    if (rst)        ctl_q <= '0;
    else if (wr_en) ctl_q <= wdata & WR_MASK;
  end
endmodule

// File: rtl/bcs_par_capture.sv
module bcs_par_capture
  import bcs_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            strobe,
  input  logic            src,
  input  logic            lane,
  input  logic [PA_W-1:0] addr,
  input  logic            ack,
  output logic            flag_q,
  output perr_cap_t       cap_q
);
  always_ff @(posedge clk) begin
    if (rst || ack) begin
      flag_q <= 1'b0;
      cap_q  <= '0;
    end else if (strobe && !flag_q) begin
      flag_q   <= 1'b1;
      cap_q.src  <= src;
      cap_q.lane <= lane;
      cap_q.hi   <= addr[PA_W-1:PA_LO_W];
      cap_q.lo   <= addr[PA_LO_W-1:0];
    end
  end
endmodule

// File: rtl/bcs_irq_merge.sv
module bcs_irq_merge (
  input  logic clk,
  input  logic rst,
  input  logic ctlr_irq,
  input  logic perr_flag,
  input  logic ien,
  input  logic pien,
  output logic irq_flag_q,
  output logic host_irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_flag_q <= 1'b0;
      host_irq_q <= 1'b0;
    end else begin
      irq_flag_q <= ctlr_irq;
      host_irq_q <= (irq_flag_q & ien) | (perr_flag & pien);
    end
  end
endmodule

// File: rtl/bcs_read_mux.sv
module bcs_read_mux
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  stat_w,
  input  logic [REG_W-1:0]  pctl_w,
  input  logic [REG_W-1:0]  plo_w,
  output logic [REG_W-1:0]  rdata_q
);
  logic [REG_W-1:0] sel_w;

  always_comb begin
    case (addr)
      ADDR_W'(OFS_STATUS): sel_w = stat_w;
      ADDR_W'(OFS_PCTL):   sel_w = pctl_w;
      ADDR_W'(OFS_PLO):    sel_w = plo_w;
      default:             sel_w = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= sel_w;
  end
endmodule

// File: rtl/bcs_regs.sv
module bcs_regs
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [REG_W-1:0]    host_wdata,
  output logic [REG_W-1:0]    host_rdata_o,
  input  logic [STRAP_W-1:0]  ram_base_strap_i,
  input  logic                ctlr_irq_i,
  input  logic                par_err_i,
  input  logic                par_src_i,
  input  logic                par_lane_i,
  input  logic [PA_W-1:0]     par_addr_i,
  output logic                ctlr_reset_o,
  output logic                on_medium_o,
  output logic                chan_attn_o,
  output logic                sec_bus_en_o,
  output logic                wide_ram_o,
  output logic                host_irq_o
);
  logic [REG_W-1:0] ctl_q;
  logic             perr_q;
  perr_cap_t        cap_q;
  logic             irq_flag_q;
  logic             stat_wr;
  logic             ack;
  logic [REG_W-1:0] stat_w, pctl_w, plo_w;

  assign stat_wr = host_wr && (host_addr == ADDR_W'(OFS_STATUS));
  assign ack     = host_wr && (host_addr == ADDR_W'(OFS_PCTL)) && host_wdata[B_ACK];

  bcs_ctrl_word u_ctrl (
    .clk(clk), .rst(rst), .wr_en(stat_wr), .wdata(host_wdata), .ctl_q(ctl_q)
  );

  bcs_par_capture u_cap (
    .clk(clk), .rst(rst), .strobe(par_err_i), .src(par_src_i),
    .lane(par_lane_i), .addr(par_addr_i), .ack(ack),
    .flag_q(perr_q), .cap_q(cap_q)
  );

  bcs_irq_merge u_irq (
    .clk(clk), .rst(rst), .ctlr_irq(ctlr_irq_i), .perr_flag(perr_q),
    .ien(ctl_q[B_IEN]), .pien(ctl_q[B_PIEN]),
    .irq_flag_q(irq_flag_q), .host_irq_q(host_irq_o)
  );

  always_comb begin
    stat_w                   = ctl_q;
    stat_w[B_PERR]           = perr_q;
    stat_w[B_IRQ]            = irq_flag_q;
    stat_w[STRAP_W-1:0]      = ram_base_strap_i;
    pctl_w                   = '0;
    pctl_w[B_SRC]            = cap_q.src;
    pctl_w[B_LANE]           = cap_q.lane;
    pctl_w[PA_HI_W-1:0]      = cap_q.hi;
    plo_w                    = cap_q.lo;
  end

  bcs_read_mux #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .rd(host_rd), .addr(host_addr),
    .stat_w(stat_w), .pctl_w(pctl_w), .plo_w(plo_w), .rdata_q(host_rdata_o)
  );

  assign ctlr_reset_o = ctl_q[B_RESET];
  assign on_medium_o  = ctl_q[B_MEDIUM];
  assign chan_attn_o  = ctl_q[B_ATTN];
  assign sec_bus_en_o = ctl_q[B_SECBUS];
  assign wide_ram_o   = ctl_q[B_WIDE];
endmodule

// File: rtl/bcs_regs_chk.sv
module bcs_regs_chk
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              host_wr,
  input logic              host_rd,
  input logic [ADDR_W-1:0] host_addr,
  input logic [REG_W-1:0]  host_wdata,
  input logic [REG_W-1:0]  host_rdata_o,
  input logic              ctlr_reset_o,
  input logic              host_irq_o,
  input logic              par_err_i,
  input logic              perr_q,
  input perr_cap_t         cap_q,
  input logic [REG_W-1:0]  ctl_q
);
  logic is_ack;
  assign is_ack = host_wr && (host_addr == ADDR_W'(OFS_PCTL)) && host_wdata[B_ACK];

  // R2
  reset_out_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == ADDR_W'(OFS_STATUS)) |=> (ctlr_reset_o == $past(host_wdata[B_RESET])));

  // R4
  capture_set_chk: assert property (@(posedge clk) disable iff (rst)
    (par_err_i && !perr_q && !is_ack) |=> perr_q);

  // R5
  capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (perr_q && !is_ack) |=> (perr_q && $stable(cap_q)));

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    is_ack |=> (!perr_q && cap_q == '0));

  // R7
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(host_irq_o) |-> $past(ctl_q[B_IEN] || ctl_q[B_PIEN]));

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(host_rdata_o));
endmodule

bind bcs_regs bcs_regs_chk #(.ADDR_W(ADDR_W)) u_bcs_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
  .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata_o(host_rdata_o),
  .ctlr_reset_o(ctlr_reset_o), .host_irq_o(host_irq_o), .par_err_i(par_err_i),
  .perr_q(perr_q), .cap_q(cap_q), .ctl_q(ctl_q)
);

// File: tb/test_bcs_regs.sv
module test_bcs_regs;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata_o;
  logic [3:0]  strap = 4'hA;
  logic        ctlr_irq = 1'b0;
  logic        perr = 1'b0, psrc = 1'b0, plane = 1'b0;
  logic [19:0] paddr = '0;
  logic        ctlr_reset_o, on_medium_o, chan_attn_o, sec_bus_en_o, wide_ram_o, host_irq_o;

  int n_run = 0, n_fail = 0;
  logic rd_seen = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bcs_regs #(.ADDR_W(AW)) i_bcs_regs (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata_o(host_rdata_o),
    .ram_base_strap_i(strap), .ctlr_irq_i(ctlr_irq), .par_err_i(perr),
    .par_src_i(psrc), .par_lane_i(plane), .par_addr_i(paddr),
    .ctlr_reset_o(ctlr_reset_o), .on_medium_o(on_medium_o), .chan_attn_o(chan_attn_o),
    .sec_bus_en_o(sec_bus_en_o), .wide_ram_o(wide_ram_o), .host_irq_o(host_irq_o)
  );

  always @(posedge clk) rd_seen <= host_rd;

  // monitor: pops the expected read data one cycle after each read
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if (host_rdata_o !== e) begin
        n_fail++;
        $display("FAIL %s read: actual %h expected %h", t, host_rdata_o, e);
      end
    end
  end

  task automatic chk(input string t, input logic [15:0] act, input logic [15:0] e);
    n_run++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", t, act, e);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [15:0] e, input string t);
    @(negedge clk); host_rd = 1'b1; host_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic strobe(input logic s, input logic l, input logic [19:0] a);
    @(negedge clk); perr = 1'b1; psrc = s; plane = l; paddr = a;
    @(negedge clk); perr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [15:0] outs();
    return {11'd0, ctlr_reset_o, on_medium_o, chan_attn_o, sec_bus_en_o, wide_ram_o};
  endfunction

  initial begin
    #(CLK_PERIOD*100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk("R1 outputs", outs(), 16'h0);
    chk("R1 irq", {15'd0, host_irq_o}, 16'h0);
    chk("R1 rdata", host_rdata_o, 16'h0);
    rd(0, 16'h000A, "R1 R3 status");
    rd(1, 16'h0000, "R1 pctl");
    rd(2, 16'h0000, "R1 plo");

    // R2 R3 writable bits, read-only bits ignored
    wr(0, 16'hFFFF);
    chk("R2 outputs set", outs(), 16'h001F);
    rd(0, 16'hF83A, "R2 R3 status mask");
    wr(0, 16'h0000);
    chk("R2 outputs clear", outs(), 16'h0);
    wr(0, 16'h2000);
    chk("R2 attn high", {15'd0, chan_attn_o}, 16'h1);
    wr(0, 16'h0000);
    chk("R2 attn low", {15'd0, chan_attn_o}, 16'h0);

    // R7 controller interrupt gating
    @(negedge clk); ctlr_irq = 1'b1;
    idle(3);
    chk("R7 irq gated off", {15'd0, host_irq_o}, 16'h0);
    rd(0, 16'h010A, "R3 irq flag");
    wr(0, 16'h1000);
    idle(2);
    chk("R7 irq enabled", {15'd0, host_irq_o}, 16'h1);
    @(negedge clk); ctlr_irq = 1'b0;
    idle(3);
    chk("R7 irq dropped", {15'd0, host_irq_o}, 16'h0);

    // R4 capture
    wr(0, 16'h0800);
    strobe(1'b1, 1'b0, 20'h51234);
    idle(2);
    chk("R7 parity irq", {15'd0, host_irq_o}, 16'h1);
    rd(0, 16'h0A0A, "R4 perr flag");
    rd(1, 16'h0085, "R4 pctl");
    rd(2, 16'h1234, "R4 plo");
    // R5 later errors ignored
    strobe(1'b0, 1'b1, 20'h3ABCD);
    rd(1, 16'h0085, "R5 pctl held");
    rd(2, 16'h1234, "R5 plo held");
    // R9 ignored writes
    wr(1, 16'h00FF);
    wr(2, 16'hFFFF);
    wr(3, 16'hFFFF);
    rd(1, 16'h0085, "R9 pctl unchanged");
    rd(2, 16'h1234, "R9 plo unchanged");
    rd(0, 16'h0A0A, "R9 status unchanged");
    // R6 acknowledge
    wr(1, 16'h0100);
    idle(1);
    chk("R6 irq cleared", {15'd0, host_irq_o}, 16'h0);
    rd(0, 16'h080A, "R6 flag cleared");
    rd(1, 16'h0000, "R6 pctl cleared");
    rd(2, 16'h0000, "R6 plo cleared");
    strobe(1'b0, 1'b1, 20'hF0001);
    rd(1, 16'h004F, "R4 lane capture");
    rd(2, 16'h0001, "R4 low addr");
    // R6 ack beats same-cycle strobe
    @(negedge clk);
    host_wr = 1'b1; host_addr = 1; host_wdata = 16'h0100;
    perr = 1'b1; psrc = 1'b1; plane = 1'b1; paddr = 20'h7777;
    @(negedge clk); host_wr = 1'b0; perr = 1'b0;
    rd(1, 16'h0000, "R6 ack priority");
    rd(0, 16'h080A, "R6 ack priority flag");

    // R8 offset 3 and hold
    rd(3, 16'h0000, "R8 offset3");
    rd(0, 16'h080A, "R8 latency");
    wr(0, 16'hC000);
    idle(2);
    chk("R8 rdata hold", host_rdata_o, 16'h080A);

    // R1 reset mid-run
    strobe(1'b1, 1'b1, 20'hFFFFF);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 rerst outputs", outs(), 16'h0);
    rd(1, 16'h0000, "R1 rerst pctl");
    rd(0, 16'h000A, "R1 rerst status");
    idle(2);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule